// File: doc/BRIEF.md
# Weighted Contention Quota Monitor

This block tracks how much contention budget one processing core still has. Software loads a quota of contention cycles. Every clock, each active event input is charged by its own programmable weight. The weights of all events that are active in the same cycle are added together, and the total is taken off the remaining quota. When the budget is used up, or will be used up by the current cycle's charge, the block raises a quota interrupt.

The remaining quota sits in a register held in three copies. The copies are combined by a bitwise majority vote, and every write refreshes all three from the voted value. A single corrupted copy therefore never reaches the output, and it is overwritten on the next clock. A fault-injection hook lets any copy be written with chosen bits inverted. This is how the masking is exercised.

Top module: `contention_budget_monitor`

## Requirements
- R1: The cycle charge is the unsigned sum of the 8-bit weights of every asserted event. Event bit i uses weights_i[8*i+7:8*i]. When no event is asserted the charge is zero.
- R2: While enable_i is high, the quota shown on quota_o after a clock edge equals the quota before that edge minus the charge of that cycle.
- R3: The quota saturates at zero. A charge greater than or equal to the remaining quota leaves zero and never wraps.
- R4: While enable_i is low and quota_load_i is high, quota_value_i becomes the quota, visible on quota_o after the next clock edge.
- R5: A load strobe while enable_i is high is ignored. Only the charge is applied.
- R6: While enable_i is low and quota_load_i is low, the quota holds its value whatever the event inputs do.
- R7: quota_irq_o is combinational in the same cycle. It is high when enable_i is high and either the quota is zero or the quota is less than or equal to the current cycle charge. Otherwise it is low.
- R8: Reset is synchronous and active low. An edge with rst_ni low sets the quota to zero. quota_irq_o is low while rst_ni is low.
- R9: The quota is stored in three copies and is read through a bitwise majority vote. Bit k of flip_sel_i inverts the flip_bits_i positions in copy k on that write. A flip of any single copy never changes quota_o. Every write restores all copies from the voted value, so two flips of different copies on successive edges are also masked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| enable_i | input | 1 | Charge events against the quota when high |
| quota_load_i | input | 1 | Load strobe, honoured only while enable_i is low |
| quota_value_i | input | QUOTA_W | Quota value to load |
| event_i | input | NUM_EVENTS | One pulse per contention event source |
| weights_i | input | NUM_EVENTS*WEIGHT_W | Weight of each event, event i in slice i |
| flip_sel_i | input | 3 | Fault injection: selects the stored copies to corrupt |
| flip_bits_i | input | QUOTA_W | Fault injection: bit positions to invert |
| quota_o | output | QUOTA_W | Remaining quota (voted register) |
| quota_irq_o | output | 1 | Quota exhausted interrupt |

## Verification
The bench goes after the charge boundary, where the quota equals the cycle charge or exceeds it by one. A design with an off-by-one comparison would fire the interrupt a cycle late or a cycle early there. It drives charges larger than the remaining quota, where a non-saturating subtract would wrap to a huge quota and silence the interrupt. Load strobes are issued with enable high; a decoder that ignores enable would load over a running budget. Copies are corrupted on consecutive edges. A voter that does not refresh every copy on each write would let two stale copies outvote the good one and change quota_o.

// File: rtl/cbm_pkg.sv
package cbm_pkg;

  // Number of redundant copies of the quota register.
  localparam int unsigned TMR_COPIES = 3;

  // What the quota register does on the next edge.
  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_LOAD   = 2'd1,
    ACT_CHARGE = 2'd2
  } quota_action_e;

  // Charging wins over loading: a strobe while enabled is dropped.
  function automatic quota_action_e pick_action(input logic enable, input logic load);
    if (enable)    return ACT_CHARGE;
    else if (load) return ACT_LOAD;
    else           return ACT_HOLD;
  endfunction

endpackage

// File: rtl/cbm_weight_adder.sv
module cbm_weight_adder #(
  parameter int unsigned NUM_EVENTS = 4,
  parameter int unsigned WEIGHT_W   = 8,
  parameter int unsigned SUM_W      = 11
) (
  input  logic [NUM_EVENTS-1:0]          event_i,
  input  logic [NUM_EVENTS*WEIGHT_W-1:0] weights_i,
  output logic [SUM_W-1:0]               sum_o
);

  // Per-event charge, zero when the event is idle.
  logic [WEIGHT_W-1:0] term [NUM_EVENTS];

  generate
    for (genvar g = 0; g < NUM_EVENTS; g++) begin : g_term
      assign term[g] = event_i[g] ? weights_i[g*WEIGHT_W +: WEIGHT_W] : '0;
    end
  endgenerate

  always_comb begin
    sum_o = '0;
    for (int i = 0; i < NUM_EVENTS; i++) begin
      sum_o = sum_o + SUM_W'(term[i]);
    end
  end

  // R1: no active event means no charge.
  always_comb begin
    if (event_i == '0) begin
      assert_idle_sum_R1: assert (sum_o == '0)
        else $error("cycle charge nonzero with no events");
    end
  end

endmodule

// File: rtl/cbm_quota_next.sv
module cbm_quota_next
  import cbm_pkg::*;
#(
  parameter int unsigned QUOTA_W = 32,
  parameter int unsigned SUM_W   = 11
) (
  input  logic               enable_i,
  input  logic               load_i,
  input  logic [QUOTA_W-1:0] load_value_i,
  input  logic [QUOTA_W-1:0] cur_q_i,
  input  logic [SUM_W-1:0]   sum_i,
  output logic [QUOTA_W-1:0] next_q_o,
  output quota_action_e      action_o,
  output logic               exhausted_o
);

  // Saturating charge: never wraps below zero.
  function automatic logic [QUOTA_W-1:0] charge(input logic [QUOTA_W-1:0] q,
                                                input logic [SUM_W-1:0]   s);
    logic [QUOTA_W-1:0] s_ext;
    s_ext = QUOTA_W'(s);
    if (s_ext >= q) return '0;
    else            return q - s_ext;
  endfunction

  // The budget runs out on this cycle's charge (or already has).
  function automatic logic used_up(input logic [QUOTA_W-1:0] q,
                                   input logic [SUM_W-1:0]   s);
    return (q == '0) || (q <= QUOTA_W'(s));
  endfunction

  assign action_o    = pick_action(enable_i, load_i);
  assign exhausted_o = used_up(cur_q_i, sum_i);

  always_comb begin
    unique case (action_o)
      ACT_CHARGE: next_q_o = charge(cur_q_i, sum_i);
      ACT_LOAD:   next_q_o = load_value_i;
      default:    next_q_o = cur_q_i;
    endcase
  end

endmodule

// File: rtl/cbm_tmr_store.sv
module cbm_tmr_store
  import cbm_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [WIDTH-1:0]      d_i,
  input  logic [TMR_COPIES-1:0] flip_sel_i,
  input  logic [WIDTH-1:0]      flip_bits_i,
  output logic [WIDTH-1:0]      q_o,
  output logic                  disagree_o
);

  localparam int unsigned ALL_W = TMR_COPIES * WIDTH;

  logic [ALL_W-1:0] copies_q;
  logic [WIDTH-1:0] cp_a, cp_b, cp_c;

  function automatic logic [WIDTH-1:0] majority(input logic [WIDTH-1:0] a,
                                                input logic [WIDTH-1:0] b,
                                                input logic [WIDTH-1:0] c);
    return (a & b) | (b & c) | (a & c);
  endfunction

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      copies_q <= '0;
    end else begin
      for (int k = 0; k < TMR_COPIES; k++) begin
        copies_q[k*WIDTH +: WIDTH] <= d_i ^ (flip_sel_i[k] ? flip_bits_i : '0);
      end
    end
  end

  assign cp_a       = copies_q[0*WIDTH +: WIDTH];
  assign cp_b       = copies_q[1*WIDTH +: WIDTH];
  assign cp_c       = copies_q[2*WIDTH +: WIDTH];
  assign q_o        = majority(cp_a, cp_b, cp_c);
  assign disagree_o = (cp_a != cp_b) || (cp_b != cp_c);

  // R9: a write with no injected flip leaves all copies equal.
  assert_repair_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flip_sel_i == '0) |=> !disagree_o)
    else $error("copies still disagree after a clean write");

endmodule

// File: rtl/contention_budget_monitor.sv
module contention_budget_monitor
  import cbm_pkg::*;
#(
  parameter int unsigned NUM_EVENTS = 4,
  parameter int unsigned WEIGHT_W   = 8,
  parameter int unsigned QUOTA_W    = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          enable_i,
  input  logic                          quota_load_i,
  input  logic [QUOTA_W-1:0]            quota_value_i,
  input  logic [NUM_EVENTS-1:0]         event_i,
  input  logic [NUM_EVENTS*WEIGHT_W-1:0] weights_i,
  input  logic [2:0]                    flip_sel_i,
  input  logic [QUOTA_W-1:0]            flip_bits_i,
  output logic [QUOTA_W-1:0]            quota_o,
  output logic                          quota_irq_o
);

  localparam int unsigned SUM_W = WEIGHT_W + $clog2(NUM_EVENTS + 1);

  logic [SUM_W-1:0]   cycle_sum;
  logic [QUOTA_W-1:0] next_q;
  logic [QUOTA_W-1:0] voted_q;
  quota_action_e      action;
  logic               budget_gone;
  logic               copies_disagree;

  cbm_weight_adder #(
    .NUM_EVENTS (NUM_EVENTS),
    .WEIGHT_W   (WEIGHT_W),
    .SUM_W      (SUM_W)
  ) u_adder (
    .event_i   (event_i),
    .weights_i (weights_i),
    .sum_o     (cycle_sum)
  );

  cbm_quota_next #(
    .QUOTA_W (QUOTA_W),
    .SUM_W   (SUM_W)
  ) u_next (
    .enable_i     (enable_i),
    .load_i       (quota_load_i),
    .load_value_i (quota_value_i),
    .cur_q_i      (voted_q),
    .sum_i        (cycle_sum),
    .next_q_o     (next_q),
    .action_o     (action),
    .exhausted_o  (budget_gone)
  );

  cbm_tmr_store #(
    .WIDTH (QUOTA_W)
  ) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .d_i         (next_q),
    .flip_sel_i  (flip_sel_i),
    .flip_bits_i (flip_bits_i),
    .q_o         (voted_q),
    .disagree_o  (copies_disagree)
  );

  assign quota_o     = voted_q;
  assign quota_irq_o = rst_ni && enable_i && budget_gone;

  // R2: an enabled cycle never raises the quota.
  assert_no_growth_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i |=> (quota_o <= $past(quota_o)))
    else $error("quota grew while charging");

  // R3: a charge at or above the remaining quota leaves zero.
  assert_floor_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && (QUOTA_W'(cycle_sum) >= quota_o)) |=> (quota_o == '0))
    else $error("quota did not saturate at zero");

  // R4: load honoured while disabled.
  assert_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && quota_load_i) |=> (quota_o == $past(quota_value_i)))
    else $error("load value not taken");

  // R5: strobe with enable high and zero charge leaves quota unchanged.
  assert_load_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && quota_load_i && (cycle_sum == '0)) |=> $stable(quota_o))
    else $error("load accepted while enabled");

  // R6: idle cycles hold.
  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && !quota_load_i) |=> $stable(quota_o))
    else $error("quota moved while idle");

  // R7: interrupt only while enabled, and always on an empty budget.
  assert_irq_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quota_irq_o |-> enable_i)
    else $error("interrupt while disabled");
  assert_irq_empty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && (quota_o == '0)) |-> quota_irq_o)
    else $error("no interrupt on empty budget");

  // R8: reset clears the quota.
  assert_reset_R8: assert property (@(posedge clk_i)
    !rst_ni |=> (quota_o == '0))
    else $error("quota not cleared by reset");

  // R9: one corrupted copy never reaches the output.
  assert_masked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(flip_sel_i) <= 1) |=> (quota_o == $past(next_q)))
    else $error("single copy flip visible at output");

endmodule

// File: tb/sim_contention_budget_monitor.sv
`timescale 1ns/100ps
module sim_contention_budget_monitor;

  localparam int NE = 4;
  localparam int WW = 8;
  localparam int QW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic          ld = 1'b0;
  logic [QW-1:0] ld_val = '0;
  logic [NE-1:0] ev = '0;
  logic [NE*WW-1:0] wts = '0;
  logic [2:0]    fsel = '0;
  logic [QW-1:0] fbits = '0;
  logic [QW-1:0] quota;
  logic          irq;

  always #2.5 clk = ~clk;

  contention_budget_monitor #(
    .NUM_EVENTS (NE), .WEIGHT_W (WW), .QUOTA_W (QW)
  ) u0 (
    .clk_i (clk), .rst_ni (rst_n), .enable_i (en), .quota_load_i (ld),
    .quota_value_i (ld_val), .event_i (ev), .weights_i (wts),
    .flip_sel_i (fsel), .flip_bits_i (fbits),
    .quota_o (quota), .quota_irq_o (irq)
  );

  typedef struct {
    logic [QW-1:0] exp;
    string         tag;
  } item_t;

  item_t         exp_q[$];
  int            checks = 0;
  int            errors = 0;
  logic [QW-1:0] model_q = '0;
  bit            done = 0;
  logic [NE*WW-1:0] wt_next = {8'd200, 8'd128, 8'd5, 8'd3};

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Charge computed independently from the R1 rule.
  function automatic int unsigned charge_of(input logic [NE-1:0] e, input logic [NE*WW-1:0] w);
    int unsigned s = 0;
    for (int i = 0; i < NE; i++) if (e[i]) s += w[i*WW +: WW];
    return s;
  endfunction

  // Driver: applies one cycle, checks the interrupt, queues the expected quota.
  task automatic step(input logic rn, input logic e_n, input logic l, input logic [QW-1:0] v,
                      input logic [NE-1:0] e, input string tag,
                      input logic [2:0] fs = 3'b000, input logic [QW-1:0] fb = '0);
    int unsigned s;
    logic        exp_irq;
    item_t       it;
    @(negedge clk);
    rst_n = rn; en = e_n; ld = l; ld_val = v; ev = e; wts = wt_next; fsel = fs; fbits = fb;
    #1;
    s = charge_of(e, wt_next);
    exp_irq = rn && e_n && ((model_q == 0) || (model_q <= s));
    check({tag, " irq R7"}, {63'd0, irq}, {63'd0, exp_irq});
    if (!rn)       model_q = '0;
    else if (e_n)  model_q = (s >= model_q) ? '0 : model_q - s;
    else if (l)    model_q = v;
    it.exp = model_q;
    it.tag = tag;
    exp_q.push_back(it);
  endtask

  // Monitor: compares the quota one edge after each driven cycle.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      item_t it;
      it = exp_q.pop_front();
      check({it.tag, " quota"}, {32'd0, quota}, {32'd0, it.exp});
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R8: reset with enable and all events active
    for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 4'hF, "R8 reset");
    // R4 load, R6 hold with events toggling
    step(1, 0, 1, 1000, 4'h0, "R4 load");
    step(1, 0, 0, 0, 4'hF, "R6 hold");
    step(1, 0, 0, 77, 4'h5, "R6 hold");
    // R5 strobe while enabled is ignored
    step(1, 1, 1, 5, 4'h0, "R5 ignored load");
    step(1, 1, 1, 9, 4'h1, "R5 ignored load charged");
    // R1/R2 single and combined events
    step(1, 1, 0, 0, 4'b0001, "R1 event0");
    step(1, 1, 0, 0, 4'b0010, "R1 event1");
    step(1, 1, 0, 0, 4'b0100, "R1 event2 top bit");
    step(1, 1, 0, 0, 4'b1000, "R1 event3");
    step(1, 1, 0, 0, 4'b0101, "R2 pair");
    step(1, 1, 0, 0, 4'b1111, "R2 all events");
    // R7 boundaries: quota equal to charge, and one above
    step(1, 0, 1, 8, 4'h0, "R4 load 8");
    step(1, 1, 0, 0, 4'b0011, "R7 equal boundary");
    step(1, 1, 0, 0, 4'b0000, "R7 empty budget");
    step(1, 0, 1, 9, 4'h0, "R4 load 9");
    step(1, 1, 0, 0, 4'b0011, "R7 one above");
    // R3 saturation
    step(1, 0, 1, 10, 4'h0, "R4 load 10");
    step(1, 1, 0, 0, 4'b1000, "R3 saturate");
    step(1, 1, 0, 0, 4'b1111, "R3 stay zero");
    // R9 single-copy flips on consecutive edges
    step(1, 0, 1, 5000, 4'h0, "R4 load 5000");
    step(1, 0, 0, 0, 4'h0, "R9 flip copy a", 3'b001, 32'hFFFF_0000);
    step(1, 0, 0, 0, 4'h0, "R9 flip copy b", 3'b010, 32'hFFFF_0000);
    step(1, 1, 0, 0, 4'b0001, "R9 flip copy c charging", 3'b100, 32'h0000_1389);
    step(1, 1, 0, 0, 4'b0010, "R9 flip copy a charging", 3'b001, 32'h8000_0001);
    step(1, 0, 0, 0, 4'h0, "R9 repaired");
    step(1, 0, 0, 0, 4'h0, "R9 repaired");
    // Random patterns against the model
    step(1, 0, 1, 100000, 4'h0, "R4 load random base");
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      r = $urandom;
      if (n % 50 == 0) wt_next = $urandom;
      step(1, (r[3:0] != 4'h0), r[4], {16'd0, r[31:16]}, r[8:5], "R2 random",
           (r[11:9] == 3'b000) ? 3'b010 : 3'b000, $urandom);
    end
    // R8 mid-run reset
    step(1, 0, 1, 777, 4'h0, "R4 load 777");
    step(0, 1, 1, 55, 4'hF, "R8 mid-run reset");
    step(1, 0, 0, 0, 4'h0, "R8 after reset");
    @(negedge clk);
    #2;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule